// File: doc/BRIEF.md
# Multichannel Inrush Window Timer and Fault Masker

This block is the digital control for a multichannel low-side switch that drives capacitive loads such as lamps. When a channel's enable input goes high, the block opens a timed inrush window for that channel. During the window the channel's current-limit select asks the analog regulator for the boosted level, which is twice the normal level. When the window has elapsed, the select drops back to the normal level. A global strap input decides whether inrush behaviour is used at all.

The window timer advances only on a periodic tick from a shared prescaler. With the defaults, a 50 MHz clock gives a 1 µs tick, and 10000 ticks give 10 ms. A channel that hits thermal shutdown during its window freezes its timer and keeps the boosted select. It resumes only after the channel reports that it has cooled below the safe threshold. Dropping the enable clears the timer, so the next rising enable starts a full window again.

Thermal faults of a channel are hidden while that channel is in its window. Faults from channels outside their windows still drive a shared active-low fault pin low. They also set sticky per-channel fault bits that software reads over a serial interface. These bits clear on the end-of-transaction pulse.

Top module: `inrush_guard`

## Requirements
- R1: With the strap high, `limitBoost[c]` is 1 from the cycle in which `chEnable[c]` rises until the edge on which `WINDOW_TICKS` prescaler ticks have been counted for that channel. Ticks come every `PRESCALE` cycles from a free-running counter started at reset. A window with no thermal event therefore lasts between (WINDOW_TICKS-1)*PRESCALE+1 and WINDOW_TICKS*PRESCALE cycles.
- R2: While `inrushStrap` is 0, every `limitBoost` bit is 0 and no fault is masked.
- R3: A channel counts as hot while `chTsd[c]` is 1, and stays hot after `chTsd[c]` falls until `chTempSafe[c]` is seen at 1. While a channel is hot, its window timer does not advance and `limitBoost[c]` stays 1.
- R4: While `chEnable[c]` is 0, the channel's timer is cleared. A later rise starts a full-length window again.
- R5: While channel c is in its window, a thermal shutdown on c neither pulls `faultN` low nor sets `faultReg[c]`.
- R6: A thermal shutdown on an enabled channel outside its window pulls `faultN` low one cycle later, even when another channel is in its window.
- R7: `faultN` is a registered output. It is 0 in the cycle after any enabled channel outside its window is hot, and 1 otherwise.
- R8: `faultReg[c]` becomes 1 one cycle after `chTsd[c]` is seen with the channel enabled and outside its window. A `spiDone` pulse clears it. If a new set and `spiDone` fall in the same cycle, the bit stays 1.
- R9: A channel whose enable is 0 affects neither `faultN` nor `faultReg`.
- R10: After synchronous active-low reset, `faultN` is 1, all `faultReg` bits are 0, and all timers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chEnable | input | NUM_CH | Per-channel enable level |
| chTsd | input | NUM_CH | Per-channel thermal shutdown flag |
| chTempSafe | input | NUM_CH | Per-channel flag: temperature below threshold minus hysteresis |
| inrushStrap | input | 1 | 1 enables inrush behaviour |
| spiDone | input | 1 | One-cycle pulse at the end of a valid serial transaction |
| limitBoost | output | NUM_CH | 1 selects the boosted current limit, 0 the normal limit |
| faultN | output | 1 | Registered active-low combined fault pin |
| faultReg | output | NUM_CH | Sticky per-channel fault bits |

## Verification
The bench builds the block with three channels, a prescaler of 3 and a window of 4 ticks. A whole window then lasts about a dozen cycles, so window expiry, pauses in the middle of a window and re-triggering all occur many times in a short run. At that size the bench can sweep every enable pattern against both strap settings, while pseudo-random thermal, cool-down and clear pulses run in the background. A cycle-by-cycle arithmetic model of the requirements is compared against all outputs, and directed cases cover the fault-masking and clear-collision corners.

// File: rtl/inrush_pkg.sv
package inrush_pkg;
  // Per-channel strobes sent from control to datapath
  typedef struct packed {
    logic clr;     // hold the window timer at zero
    logic adv;     // count one tick of the window
    logic fltSet;  // latch an unmasked thermal fault
  } chStrobe_t;
endpackage

// File: rtl/inrush_dpath.sv
module inrush_dpath
  import inrush_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int PRESCALE     = 50,
  parameter int WINDOW_TICKS = 10000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  chStrobe_t [NUM_CH-1:0] strobe,
  input  logic                  spiDone,
  output logic                  tick,
  output logic [NUM_CH-1:0]     winDone,
  output logic [NUM_CH-1:0]     faultReg
);
  localparam int PRE_W = $clog2(PRESCALE + 1);
  localparam int CNT_W = $clog2(WINDOW_TICKS + 1);

  logic [PRE_W-1:0] preCnt;

  // Free-running tick generator shared by all channels
  always_ff @(posedge clk) begin
    if (!rst_n) preCnt <= '0;
    else if (preCnt == PRE_W'(PRESCALE - 1)) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end
  assign tick = (preCnt == PRE_W'(PRESCALE - 1));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0] winCnt;

    always_ff @(posedge clk) begin
      if (!rst_n || strobe[c].clr) begin
        winCnt     <= '0;
        winDone[c] <= 1'b0;
      end else if (strobe[c].adv) begin
        if (winCnt == CNT_W'(WINDOW_TICKS - 1)) begin
          winCnt     <= '0;
          winDone[c] <= 1'b1;
        end else begin
          winCnt <= winCnt + 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) faultReg[c] <= 1'b0;
      else        faultReg[c] <= strobe[c].fltSet | (faultReg[c] & ~spiDone);
    end

    always_comb begin
      AST_CNT_IN_RANGE: assert (!rst_n || winCnt < CNT_W'(WINDOW_TICKS)); // R1
    end

    AST_DONE_NEEDS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(winDone[c]) |-> $past(strobe[c].adv)); // R1
  end

  if (PRESCALE > 1) begin : g_tickChk
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R1
  end
endmodule

// File: rtl/inrush_ctrl.sv
module inrush_ctrl
  import inrush_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH-1:0]      chEnable,
  input  logic [NUM_CH-1:0]      chTsd,
  input  logic [NUM_CH-1:0]      chTempSafe,
  input  logic                   inrushStrap,
  input  logic                   tick,
  input  logic [NUM_CH-1:0]      winDone,
  output chStrobe_t [NUM_CH-1:0] strobe,
  output logic [NUM_CH-1:0]      limitBoost,
  output logic                   faultN
);
  logic [NUM_CH-1:0] hotReg;
  logic [NUM_CH-1:0] hotNow;
  logic [NUM_CH-1:0] inWindow;
  logic [NUM_CH-1:0] pinFault;

  // Thermal state: hot from shutdown until the safe flag is seen
  always_ff @(posedge clk) begin
    if (!rst_n) hotReg <= '0;
    else        hotReg <= chTsd | (hotReg & ~chTempSafe);
  end
  assign hotNow   = chTsd | hotReg;
  assign inWindow = chEnable & {NUM_CH{inrushStrap}} & ~winDone;
  assign pinFault = chEnable & ~inWindow & hotNow;
  assign limitBoost = inWindow;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign strobe[c].clr    = ~chEnable[c] | ~inrushStrap;
    assign strobe[c].adv    = inWindow[c] & tick & ~hotNow[c];
    assign strobe[c].fltSet = chTsd[c] & chEnable[c] & ~inWindow[c];

    AST_HOT_KEEPS_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
      (limitBoost[c] && hotNow[c]) |=> (limitBoost[c] || !chEnable[c] || !inrushStrap)); // R3
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (!chEnable[c]) |=> !winDone[c]); // R4
    AST_PIN_LOW_ON_TSD: assert property (@(posedge clk) disable iff (!rst_n)
      (chEnable[c] && !limitBoost[c] && chTsd[c]) |=> !faultN); // R6
  end

  always_ff @(posedge clk) begin
    if (!rst_n) faultN <= 1'b1;
    else        faultN <= ~|pinFault;
  end

  AST_PIN_HIGH_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chEnable == '0) |=> faultN); // R9
endmodule

// File: rtl/inrush_guard.sv
module inrush_guard
  import inrush_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int PRESCALE     = 50,
  parameter int WINDOW_TICKS = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] chTsd,
  input  logic [NUM_CH-1:0] chTempSafe,
  input  logic              inrushStrap,
  input  logic              spiDone,
  output logic [NUM_CH-1:0] limitBoost,
  output logic              faultN,
  output logic [NUM_CH-1:0] faultReg
);
  chStrobe_t [NUM_CH-1:0] strobe;
  logic                   tick;
  logic [NUM_CH-1:0]      winDone;

  inrush_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .chEnable(chEnable), .chTsd(chTsd),
    .chTempSafe(chTempSafe), .inrushStrap(inrushStrap), .tick(tick),
    .winDone(winDone), .strobe(strobe), .limitBoost(limitBoost), .faultN(faultN)
  );

  inrush_dpath #(.NUM_CH(NUM_CH), .PRESCALE(PRESCALE), .WINDOW_TICKS(WINDOW_TICKS)) i_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .spiDone(spiDone),
    .tick(tick), .winDone(winDone), .faultReg(faultReg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_MASKED_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (limitBoost[c] && !faultReg[c]) |=> !faultReg[c]); // R5
    AST_BIT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (chTsd[c] && chEnable[c] && !limitBoost[c]) |=> faultReg[c]); // R8
  end
endmodule

// File: tb/test_inrush_guard.sv
module test_inrush_guard;
  localparam int N = 3;
  localparam int P = 3;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] chEnable = '0, chTsd = '0, chTempSafe = '0;
  logic inrushStrap = 1'b1, spiDone = 1'b0;
  logic [N-1:0] limitBoost, faultReg;
  logic faultN;

  int checks = 0, errors = 0;
  bit cmpOn = 1'b0;
  bit finished = 1'b0;

  // reference state computed from the requirements
  int mPre = 0;
  int mCnt [N];
  bit mDone [N], mHot [N], mFreg [N];
  bit mFaultN = 1'b1;

  always #10 clk = ~clk;

  inrush_guard #(.NUM_CH(N), .PRESCALE(P), .WINDOW_TICKS(W)) i_inrush_guard (
    .clk(clk), .rst_n(rst_n), .chEnable(chEnable), .chTsd(chTsd),
    .chTempSafe(chTempSafe), .inrushStrap(inrushStrap), .spiDone(spiDone),
    .limitBoost(limitBoost), .faultN(faultN), .faultReg(faultReg)
  );

  function automatic bit expWin(int c);
    return chEnable[c] && inrushStrap && !mDone[c];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mPre = 0; mFaultN = 1'b1;
      for (int c = 0; c < N; c++) begin mCnt[c] = 0; mDone[c] = 0; mHot[c] = 0; mFreg[c] = 0; end
    end else begin
      bit tk;
      bit anyF;
      tk = (mPre == P - 1);
      anyF = 1'b0;
      for (int c = 0; c < N; c++) begin
        bit hotNow, win;
        hotNow = chTsd[c] || mHot[c];
        win = expWin(c);
        if (chEnable[c] && !win && hotNow) anyF = 1'b1;
        mFreg[c] = (chTsd[c] && chEnable[c] && !win) || (mFreg[c] && !spiDone);
        mHot[c] = chTsd[c] || (mHot[c] && !chTempSafe[c]);
        if (!chEnable[c] || !inrushStrap) begin mCnt[c] = 0; mDone[c] = 0; end
        else if (win && tk && !hotNow) begin
          if (mCnt[c] == W - 1) begin mCnt[c] = 0; mDone[c] = 1; end
          else mCnt[c]++;
        end
      end
      mFaultN = !anyF;
      mPre = tk ? 0 : mPre + 1;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (cmpOn && rst_n) begin
      for (int c = 0; c < N; c++) begin
        check(limitBoost[c] == expWin(c), "R1/R3 limitBoost", limitBoost[c], expWin(c));
        check(faultReg[c] == mFreg[c], "R8 faultReg", faultReg[c], mFreg[c]);
      end
      check(faultN == mFaultN, "R7 faultN", faultN, mFaultN);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  task automatic rndStep(bit keepEn);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    chTsd = lfsr[2:0] & lfsr[5:3] & lfsr[8:6];
    chTempSafe = lfsr[11:9];
    spiDone = lfsr[12] & lfsr[13];
    if (!keepEn) begin
      chEnable = lfsr[15] ? chEnable ^ (3'b1 << (lfsr[14:13] % 3)) : chEnable;
      inrushStrap = !(lfsr[15:12] == 4'hF);
    end
  endtask

  initial begin
    int len;
    cyc(3);
    #2;
    check(faultN == 1'b1, "R10 faultN reset", faultN, 1);
    check(faultReg == '0, "R10 faultReg reset", faultReg, 0);
    check(limitBoost == '0, "R10 limitBoost reset", limitBoost, 0);
    rst_n = 1'b1;
    cmpOn = 1'b1;
    cyc(2);

    // R1: undisturbed window length
    chEnable = 3'b001;
    len = 0;
    for (int i = 0; i < 40; i++) begin
      #2; if (limitBoost[0]) len++;
      @(negedge clk);
    end
    check(len >= (W-1)*P+1 && len <= W*P, "R1 window length", len, W*P);

    // R5 / R3: shutdown inside own window is masked and pauses
    chEnable[1] = 1'b1; chTsd[1] = 1'b1;
    cyc(1); chTsd[1] = 1'b0; #2;
    check(faultN == 1'b1, "R5 pin masked", faultN, 1);
    check(faultReg[1] == 1'b0, "R5 bit masked", faultReg[1], 0);
    cyc(30); #2;
    check(limitBoost[1] == 1'b1, "R3 paused window holds boost", limitBoost[1], 1);

    // R6: channel 0 outside window faults while channel 1 in window
    @(negedge clk); chTsd[0] = 1'b1;
    cyc(1); chTsd[0] = 1'b0; #2;
    check(faultN == 1'b0, "R6 pin from other channel", faultN, 0);
    check(faultReg[0] == 1'b1, "R8 bit set", faultReg[0], 1);
    cyc(1); #2;
    check(faultN == 1'b0, "R7 pin held until safe", faultN, 0);
    @(negedge clk); chTempSafe = 3'b111;
    cyc(1); chTempSafe = '0;
    cyc(1); #2;
    check(faultN == 1'b1, "R7 pin released", faultN, 1);
    cyc(20); #2;
    check(limitBoost[1] == 1'b0, "R3 window resumes and ends", limitBoost[1], 0);

    // R8: set beats clear, then clear alone
    @(negedge clk); spiDone = 1'b1; chTsd[0] = 1'b1;
    cyc(1); spiDone = 1'b0; chTsd[0] = 1'b0; chTempSafe = 3'b111; #2;
    check(faultReg[0] == 1'b1, "R8 set wins over clear", faultReg[0], 1);
    @(negedge clk); spiDone = 1'b1;
    cyc(1); spiDone = 1'b0; #2;
    check(faultReg == '0, "R8 cleared by spiDone", faultReg, 0);

    // R9: disabled channel contributes nothing
    @(negedge clk); chEnable = '0; chTsd[2] = 1'b1;
    cyc(1); chTsd[2] = 1'b0; #2;
    check(faultN == 1'b1, "R9 pin unaffected", faultN, 1);
    check(faultReg[2] == 1'b0, "R9 bit unaffected", faultReg[2], 0);

    // R2: strap low, no boost and no masking
    @(negedge clk); inrushStrap = 1'b0; chEnable = 3'b111; chTempSafe = '0; #2;
    check(limitBoost == '0, "R2 no boost", limitBoost, 0);
    @(negedge clk); chTsd[1] = 1'b1;
    cyc(1); chTsd[1] = 1'b0; chTempSafe = 3'b111; #2;
    check(faultN == 1'b0, "R2 pin not masked", faultN, 0);
    check(faultReg[1] == 1'b1, "R2 bit not masked", faultReg[1], 1);

    // R4: drop enable mid-window, re-rise gives a full window
    @(negedge clk); inrushStrap = 1'b1; chEnable = '0; spiDone = 1'b1;
    cyc(1); spiDone = 1'b0; chEnable[0] = 1'b1;
    cyc(6); chEnable[0] = 1'b0;
    cyc(1); chEnable[0] = 1'b1;
    len = 0;
    for (int i = 0; i < 40; i++) begin
      #2; if (limitBoost[0]) len++;
      @(negedge clk);
    end
    check(len >= (W-1)*P+1 && len <= W*P, "R4 restart full window", len, W*P);

    // sweep of every enable pattern against both strap settings
    for (int pat = 0; pat < 16; pat++) begin
      chEnable = pat[2:0]; inrushStrap = pat[3];
      for (int k = 0; k < 40; k++) begin rndStep(1'b1); @(negedge clk); end
    end
    // free-running pseudo-random traffic
    for (int k = 0; k < 2000; k++) begin rndStep(1'b0); @(negedge clk); end

    cmpOn = 1'b0;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule